// File: doc/BRIEF.md
# SIMD Issue Stage with Double-Precision Throttle

This block sits between instruction decode and two arithmetic pipelines: a four-lane single-precision fused multiply-add unit and a single double-precision fused multiply-add unit. It accepts one instruction per cycle over a valid/ready handshake. It issues instructions strictly in order and tells the rest of the core when each result comes back. The arithmetic is not modelled. Every instruction travels as a tagged token whose return cycle is set by its class latency.

Three rules gate each issue. First, a double-precision issue opens a bubble in which nothing else issues. The bubble is six cycles by default, and one cycle when the relaxed mode parameter is set. Second, a source tag that names the destination of an op still in flight holds the instruction back until that op's writeback cycle. Third, the writeback port carries one result per cycle. When two results fall in the same cycle, the older one keeps its slot and the younger one moves to the next free cycle.

Top module: `simd_issue_stage`

## Requirements
- R1: After reset, no issue strobe and no writeback are shown, and `in_ready` is high.
- R2: The class code 2'b01 is a single-precision op. Its handshake raises `iss_sp` with `iss_tag` on the next cycle, and its writeback (`wb_valid` with `wb_tag`) appears 6 cycles after the strobe cycle.
- R3: The class code 2'b10 is a double-precision op. It raises `iss_dp`, and its writeback appears 13 cycles after the strobe (9 arithmetic cycles plus 4 movement cycles).
- R4: The class codes 2'b00 and 2'b11 are other ops. They raise `iss_ot`, and their writeback appears 2 cycles after the strobe.
- R5: With `RELAXED_DP` = 0, `in_ready` stays low for the 6 cycles that follow a double-precision handshake. The next handshake can therefore come no sooner than 7 cycles after it.
- R6: With `RELAXED_DP` = 1, the bubble after a double-precision handshake lasts one cycle, so double-precision ops can issue every second cycle. All latencies stay the same.
- R7: With no hazard and no bubble, single-precision and other ops are accepted on consecutive cycles.
- R8: An instruction whose `in_src_a` or `in_src_b` equals the destination tag of an op in flight is held until the cycle in which that op's writeback is shown. It is accepted at the end of that cycle.
- R9: While `in_ready` is low, no handshake takes place and no issue strobe follows.
- R10: If two results would reach writeback in the same cycle, the earlier-issued op retires in that cycle and the later one retires in the first free cycle after it.
- R11: At most one issue strobe and one writeback appear in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Upstream instruction present |
| in_ready | output | 1 | Stage accepts the instruction this cycle |
| in_class | input | 2 | 00 other, 01 single-precision FMA, 10 double-precision FMA, 11 other |
| in_dst | input | TAG_W | Destination register tag |
| in_src_a | input | TAG_W | First source register tag |
| in_src_b | input | TAG_W | Second source register tag |
| iss_sp | output | 1 | Single-precision issue strobe |
| iss_dp | output | 1 | Double-precision issue strobe |
| iss_ot | output | 1 | Other-op issue strobe |
| iss_tag | output | TAG_W | Destination tag of the op issued |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_tag | output | TAG_W | Destination tag of the result written back |

## Verification
The assertions assume that upstream keeps `in_valid` high and leaves the class and tag fields unchanged while `in_ready` is low. The bench meets this by changing an instruction only after its handshake edge or while `in_valid` is low. The bench uses tag 31 as the source of every instruction that is meant to be independent and never uses 31 as a destination. As a result, only the dependency test creates a hazard. The measured bubbles and return cycles then come from the throttle and the latencies alone.

// File: rtl/issue_pkg.sv
// Shared definitions for the SIMD issue stage.
// Assumes: the two-bit class code comes straight from the decoder.
package issue_pkg;
    typedef enum logic [1:0] {
        OP_OTHER = 2'b00,
        OP_SP    = 2'b01,
        OP_DP    = 2'b10,
        OP_RSVD  = 2'b11
    } op_class_e;
endpackage

// File: rtl/issue_gap_timer.sv
// Issue bubble timer: after a load, holds 'open' low for GAP cycles.
// Assumes: load only on an accepted double-precision op (never while closed).
module issue_gap_timer #(
    parameter int GAP   = 6,
    parameter int GAP_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic open
);
    logic [GAP_W-1:0] cnt;

    // Count down the remaining bubble cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= GAP_W'(GAP);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign open = (cnt == '0);

    // R5 R6
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (GAP != 0)) |=> !open);
endmodule

// File: rtl/issue_wb_sched.sv
// Writeback slot scheduler: a shift register of future writeback cycles.
// An op is placed in the first free slot at or after its latency, so an
// older op keeps its cycle and a younger one slips later. Slot 0 is the
// result retiring in the current cycle. The module also reports source
// hazards against any entry that has not reached slot 0.
// Assumes: ins_en only when room is high; ins_lat < DEPTH.
module issue_wb_sched #(
    parameter int TAG_W = 5,
    parameter int DEPTH = 18,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic [IDX_W-1:0] ins_lat,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic [TAG_W-1:0] chk_a,
    input  logic [TAG_W-1:0] chk_b,
    output logic             haz,
    output logic             room,
    output logic             wb_valid,
    output logic [TAG_W-1:0] wb_tag
);
    logic [DEPTH-1:0] slot_v;
    logic [TAG_W-1:0] slot_tag [DEPTH];
    logic [DEPTH-1:0] shift_v;
    logic [TAG_W-1:0] shift_tag [DEPTH];
    logic [IDX_W-1:0] pos;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            if (g < DEPTH - 1) begin : g_mid
                assign shift_v[g]   = slot_v[g+1];
                assign shift_tag[g] = slot_tag[g+1];
            end else begin : g_top
                assign shift_v[g]   = 1'b0;
                assign shift_tag[g] = '0;
            end
            // Advance one slot per cycle, or take the newly issued op.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_v[g]   <= 1'b0;
                    slot_tag[g] <= '0;
                end else if (ins_en && pos == IDX_W'(g)) begin
                    slot_v[g]   <= 1'b1;
                    slot_tag[g] <= ins_tag;
                end else begin
                    slot_v[g]   <= shift_v[g];
                    slot_tag[g] <= shift_tag[g];
                end
            end
        end
    endgenerate

    // Find the earliest free slot at or after the requested latency.
    always_comb begin
        room = 1'b0;
        pos  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (i >= int'(ins_lat) && !shift_v[i]) begin
                room = 1'b1;
                pos  = IDX_W'(i);
            end
        end
    end

    // Flag a source that matches a result not yet at writeback.
    always_comb begin
        haz = 1'b0;
        for (int i = 1; i < DEPTH; i++) begin
            if (slot_v[i] && (slot_tag[i] == chk_a || slot_tag[i] == chk_b))
                haz = 1'b1;
        end
    end

    assign wb_valid = slot_v[0];
    assign wb_tag   = slot_tag[0];

    // R11
    occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_v) <= $past($countones(slot_v)) + 1);

    // R2
    ins_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> (slot_v != '0));
endmodule

// File: rtl/simd_issue_stage.sv
// In-order single-issue stage feeding a single-precision and a
// double-precision FMA pipeline. It holds issue during the bubble after a
// double-precision op, on a source hazard, or when no writeback slot is
// free. It reports issue strobes and writeback tokens.
// Assumes: upstream holds in_valid and the fields steady while in_ready is low.
module simd_issue_stage #(
    parameter int TAG_W      = 5,
    parameter int LAT_SP     = 6,
    parameter int LAT_DP     = 13,
    parameter int LAT_OT     = 2,
    parameter int DP_BUBBLE  = 6,
    parameter bit RELAXED_DP = 1'b0,
    parameter int SLACK      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_class,
    input  logic [TAG_W-1:0] in_dst,
    input  logic [TAG_W-1:0] in_src_a,
    input  logic [TAG_W-1:0] in_src_b,
    output logic             iss_sp,
    output logic             iss_dp,
    output logic             iss_ot,
    output logic [TAG_W-1:0] iss_tag,
    output logic             wb_valid,
    output logic [TAG_W-1:0] wb_tag
);
    import issue_pkg::*;

    localparam int DEPTH = LAT_DP + SLACK + 1;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int GAP   = RELAXED_DP ? 1 : DP_BUBBLE;
    localparam int GAP_W = (GAP < 1) ? 1 : $clog2(GAP + 1);

    op_class_e        cls;
    logic [IDX_W-1:0] lat;
    logic             fire, gap_open, haz, room;

    assign cls = op_class_e'(in_class);

    // Pick the writeback latency for the incoming class.
    always_comb begin
        unique case (cls)
            OP_SP:   lat = IDX_W'(LAT_SP);
            OP_DP:   lat = IDX_W'(LAT_DP);
            default: lat = IDX_W'(LAT_OT);
        endcase
    end

    assign in_ready = gap_open && !haz && room;
    assign fire     = in_valid && in_ready;

    issue_gap_timer #(.GAP(GAP), .GAP_W(GAP_W)) u_gap (
        .clk  (clk),
        .rst_n(rst_n),
        .load (fire && cls == OP_DP),
        .open (gap_open)
    );

    issue_wb_sched #(.TAG_W(TAG_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .ins_en  (fire),
        .ins_lat (lat),
        .ins_tag (in_dst),
        .chk_a   (in_src_a),
        .chk_b   (in_src_b),
        .haz     (haz),
        .room    (room),
        .wb_valid(wb_valid),
        .wb_tag  (wb_tag)
    );

    // Register the one-cycle issue strobes for the accepted op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_sp  <= 1'b0;
            iss_dp  <= 1'b0;
            iss_ot  <= 1'b0;
            iss_tag <= '0;
        end else begin
            iss_sp  <= fire && cls == OP_SP;
            iss_dp  <= fire && cls == OP_DP;
            iss_ot  <= fire && (cls == OP_OTHER || cls == OP_RSVD);
            iss_tag <= fire ? in_dst : iss_tag;
        end
    end

    // R11
    iss_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({iss_sp, iss_dp, iss_ot}));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=>
            (in_valid && $stable({in_class, in_dst, in_src_a, in_src_b})));

    // R5 R6
    dp_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_dp |=> (!iss_dp && (RELAXED_DP || !(iss_sp || iss_ot))));
endmodule

// File: tb/simd_issue_stage_test.sv
module simd_issue_stage_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       in_valid, in_ready, iss_sp, iss_dp, iss_ot, wb_valid;
    logic [1:0] in_class;
    logic [4:0] in_dst, in_src_a, in_src_b, iss_tag, wb_tag;
    logic       r_valid, r_ready, r_sp, r_dp, r_ot, r_wbv;
    logic [1:0] r_class;
    logic [4:0] r_dst, r_tag, r_wbt;

    simd_issue_stage uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_class(in_class), .in_dst(in_dst), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .iss_sp(iss_sp), .iss_dp(iss_dp), .iss_ot(iss_ot),
        .iss_tag(iss_tag), .wb_valid(wb_valid), .wb_tag(wb_tag));

    simd_issue_stage #(.RELAXED_DP(1'b1)) uut_relaxed (
        .clk(clk), .rst_n(rst_n), .in_valid(r_valid), .in_ready(r_ready),
        .in_class(r_class), .in_dst(r_dst), .in_src_a(5'd31),
        .in_src_b(5'd31), .iss_sp(r_sp), .iss_dp(r_dp), .iss_ot(r_ot),
        .iss_tag(r_tag), .wb_valid(r_wbv), .wb_tag(r_wbt));

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int wb_cyc [32];
    int r_wb_cyc [32];

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (wb_valid) wb_cyc[wb_tag] = cyc;
        if (r_wbv)    r_wb_cyc[r_wbt] = cyc;
    end

    typedef struct packed {
        logic [1:0] cls;
        logic [4:0] tag;
        int         lat;
        int         gap;
    } vec_t;
    localparam vec_t VEC [4] = '{
        '{2'b01, 5'd5, 6, 0},
        '{2'b10, 5'd6, 13, 6},
        '{2'b00, 5'd7, 2, 0},
        '{2'b11, 5'd8, 2, 0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic [1:0] c, input logic [4:0] d, input logic [4:0] sa);
        in_valid = 1'b1; in_class = c; in_dst = d; in_src_a = sa; in_src_b = 5'd31;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        r_valid  = 1'b0;
        repeat (n) step();
    endtask

    task automatic clear_log();
        for (int i = 0; i < 32; i++) begin
            wb_cyc[i] = -1;
            r_wb_cyc[i] = -1;
        end
    endtask

    // Count cycles with ready low, then take the handshake edge.
    task automatic wait_accept(output int n);
        n = 0;
        #1;
        while (!in_ready) begin
            n++;
            @(posedge clk);
            #2;
        end
        step();
    endtask

    task automatic run_all();
        int c0, n;
        string req;
        logic [2:0] exp_s;
        in_valid = 0; in_class = 0; in_dst = 0; in_src_a = 31; in_src_b = 31;
        r_valid = 0; r_class = 0; r_dst = 0;
        clear_log();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(!(iss_sp || iss_dp || iss_ot), "R1 strobes", {iss_sp, iss_dp, iss_ot}, 0);
        chk(!wb_valid, "R1 wb_valid", wb_valid, 0);
        #1 chk(in_ready, "R1 in_ready", in_ready, 1);

        // Table walk: each class alone, its bubble and its latency
        foreach (VEC[k]) begin
            idle(20);
            clear_log();
            drive(VEC[k].cls, VEC[k].tag, 5'd31);
            #1 chk(in_ready, "R7 ready when idle", in_ready, 1);
            step();
            c0 = cyc;
            exp_s = {VEC[k].cls == 2'b01, VEC[k].cls == 2'b10,
                     VEC[k].cls == 2'b00 || VEC[k].cls == 2'b11};
            req = (VEC[k].cls == 2'b01) ? "R2" : (VEC[k].cls == 2'b10) ? "R3" : "R4";
            chk({iss_sp, iss_dp, iss_ot} == exp_s && iss_tag == VEC[k].tag,
                {req, " strobe"}, {iss_sp, iss_dp, iss_ot}, exp_s);
            drive(2'b00, 5'd30, 5'd31);
            wait_accept(n);
            in_valid = 1'b0;
            chk(n == VEC[k].gap, "R5 R9 bubble after op", n, VEC[k].gap);
            while (wb_cyc[VEC[k].tag] < 0) step();
            chk(wb_cyc[VEC[k].tag] - c0 == VEC[k].lat, {req, " latency"},
                wb_cyc[VEC[k].tag] - c0, VEC[k].lat);
        end

        // R8 dependency on an in-flight single-precision result
        idle(20);
        clear_log();
        drive(2'b01, 5'd3, 5'd31);
        step();
        drive(2'b00, 5'd4, 5'd3);
        n = 0;
        #1;
        while (!in_ready) begin
            n++;
            @(posedge clk);
            #2;
        end
        chk(n == 6, "R8 hazard hold cycles", n, 6);
        chk(wb_valid && wb_tag == 5'd3, "R8 accept in writeback cycle", wb_tag, 3);
        step();
        in_valid = 1'b0;

        // R7 back-to-back issue and R10 writeback collision
        idle(25);
        clear_log();
        drive(2'b01, 5'd1, 5'd31);
        step();
        c0 = cyc;
        for (int j = 0; j < 4; j++) begin
            drive(2'b00, 5'(11 + j), 5'd31);
            #1 chk(in_ready, "R7 consecutive accept", in_ready, 1);
            step();
        end
        idle(12);
        chk(wb_cyc[11] - c0 == 3, "R10 first other", wb_cyc[11] - c0, 3);
        chk(wb_cyc[13] - c0 == 5, "R10 third other", wb_cyc[13] - c0, 5);
        chk(wb_cyc[1] - c0 == 6, "R10 older keeps slot", wb_cyc[1] - c0, 6);
        chk(wb_cyc[14] - c0 == 7, "R10 younger slips", wb_cyc[14] - c0, 7);

        // R6 relaxed mode: double-precision every second cycle
        idle(5);
        clear_log();
        r_valid = 1'b1; r_class = 2'b10; r_dst = 5'd9;
        step();
        c0 = cyc;
        r_dst = 5'd10;
        n = 0;
        #1;
        while (!r_ready) begin
            n++;
            @(posedge clk);
            #2;
        end
        step();
        r_valid = 1'b0;
        chk(n == 1, "R6 relaxed bubble", n, 1);
        idle(20);
        chk(r_wb_cyc[10] - c0 == 15, "R6 relaxed latency", r_wb_cyc[10] - c0, 15);
        chk(r_wb_cyc[9] - c0 == 13, "R6 first dp latency", r_wb_cyc[9] - c0, 13);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL R11 watchdog actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule